// File: doc/BRIEF.md
# Message-Signalled Interrupt Collector

The block gathers eleven interrupt source lines and turns each new rising level into a single 32-bit memory-write message. It keeps three pieces of state for each source. The first is a copy of the line's current level. The second is a sticky pending flag that records rising edges. The third is a pair of per-source settings: an enable (mask) bit and a class bit. The class bit picks one of two target registers. Each target register packs the message address into bits 31:5 and the message data into bits 4:0. When an enabled source rises, the block sends the write on a request/acknowledge master port. The address is the target value with its low five bits cleared, and the data is those five bits.

Software reaches every register through a small word-wide register port. Two derived views show the asserted, enabled sources split by class. The pending register clears itself whenever it is accessed. In the default source numbering, bits 0 to 5 are the six PCI interrupt lines, bit 6 is an external bus interrupt, bit 7 is a bus error, bit 8 is the PS/2 port and bit 10 is the serial port. Bit 9 is unused.

Several sources can rise in the same cycle. Their messages are queued and sent one at a time, lowest source number first.

Top module: `irq_msg_ctrl`

## Requirements
- R1: After reset, the level, pending, mask and class registers read 0, msg_req is low, and both target registers read MSG_BASE+3 (default 32'hFFF8_0003).
- R2: The level register holds the value src_i had at the previous clock edge. Register index map (cfg_idx): 0 level, 1 pending, 2 mask, 3 class, 4 target 0, 5 target 1, 6 request view 0, 7 request view 1. A read on cfg_idx returns its data on cfg_rdata, zero-extended, in the cycle after the access, with cfg_rvalid high.
- R3: A pending bit is set only when a source is seen high while its level bit is clear. A source that stays high sets nothing more after its pending bit has been cleared.
- R4: Request view 0 reads level & mask & ~class. Request view 1 reads level & mask & class.
- R5: A read of the pending register returns its value and clears it. A write to it clears it whatever the data. An edge seen in the same cycle as the clear stays pending.
- R6: Writes to the level register and to both request views have no effect.
- R7: A rising edge on a source whose mask bit is 1 produces one message. The target is target 1 if the source's class bit (sampled at the edge) is 1, else target 0. The register is read when the message is issued. msg_addr = target & 32'hFFFF_FFE0 and msg_data = target & 32'h1F. An edge on a masked source produces no message.
- R8: Once msg_req is high, it stays high with msg_addr and msg_data unchanged until a cycle in which msg_ack is high.
- R9: Messages for sources that rise together go out one per acknowledge, in increasing source number.
- R10: Mask and class keep the low 11 bits of the written data. The target registers keep all 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | 11 | Interrupt source levels, synchronous to clk |
| cfg_en | input | 1 | Register access strobe |
| cfg_wr | input | 1 | 1 = write, 0 = read |
| cfg_idx | input | 3 | Register index |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, one cycle after the access |
| cfg_rvalid | output | 1 | Read data valid |
| msg_req | output | 1 | Message write request |
| msg_addr | output | 32 | Message address |
| msg_data | output | 32 | Message data |
| msg_ack | input | 1 | Message accepted |

## Verification
Wrong edge tracking shows up in the pending register one cycle after the line moves. It takes one of two forms: a flag that reappears while a source is held high, or an edge that is missing. A corrupt queue or a wrong class capture appears at the message port within two cycles of the edge. It shows as a message going to the wrong target, in the wrong order, missing, or duplicated. A mis-handled clear shows on the very next read of the pending register.

// File: rtl/irq_msg_pkg.sv
// Package: register index encoding and shared widths for the interrupt collector.
package irq_msg_pkg;
    localparam int WORD_W    = 32;
    localparam int REG_IDX_W = 3;
    localparam int DATA_BITS = 5;   // low target bits carried as message data

    typedef enum logic [REG_IDX_W-1:0] {
        REG_LEVEL = 3'd0,
        REG_PEND  = 3'd1,
        REG_MASK  = 3'd2,
        REG_CLASS = 3'd3,
        REG_TGT0  = 3'd4,
        REG_TGT1  = 3'd5,
        REG_REQ0  = 3'd6,
        REG_REQ1  = 3'd7
    } irq_reg_e;
endpackage

// File: rtl/irq_edge_track.sv
// Level tracker: registers each source line and flags a rise when the line
// is high while the stored level is still low.
// Assumes src_i is already synchronous to clk.
module irq_edge_track #(
    parameter int NUM_SRC = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    output logic [NUM_SRC-1:0] lvl_o,
    output logic [NUM_SRC-1:0] rise_o
);
    logic [NUM_SRC-1:0] lvl_q;

    // Purpose: capture the current source levels every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= src_i;
    end

    // Purpose: new rise = line high while recorded level is low.
    always_comb begin
        rise_o = src_i & ~lvl_q;
    end

    assign lvl_o = lvl_q;
endmodule

// File: rtl/irq_regfile.sv
// Register file: mask, class, two packed targets and the pending register.
// Also provides the read multiplexer.
// Assumes one access per cycle on the register port. Pending clears on any
// access to its index, and edges arriving in that same cycle are kept.
module irq_regfile
    import irq_msg_pkg::*;
#(
    parameter int          NUM_SRC  = 11,
    parameter logic [31:0] TGT_INIT = 32'hFFF8_0003
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_en,
    input  logic                 cfg_wr,
    input  logic [REG_IDX_W-1:0] cfg_idx,
    input  logic [WORD_W-1:0]    cfg_wdata,
    output logic [WORD_W-1:0]    cfg_rdata,
    output logic                 cfg_rvalid,
    input  logic [NUM_SRC-1:0]   lvl_i,
    input  logic [NUM_SRC-1:0]   rise_i,
    output logic [NUM_SRC-1:0]   mask_o,
    output logic [NUM_SRC-1:0]   cls_o,
    output logic [NUM_SRC-1:0]   pend_o,
    output logic [WORD_W-1:0]    tgt0_o,
    output logic [WORD_W-1:0]    tgt1_o
);
    logic [NUM_SRC-1:0] mask_q, cls_q, pend_q;
    logic [WORD_W-1:0]  tgt0_q, tgt1_q;
    logic [WORD_W-1:0]  rd_mux;
    logic               do_wr, do_rd, pend_clr;
    irq_reg_e           idx;

    assign idx      = irq_reg_e'(cfg_idx);
    assign do_wr    = cfg_en && cfg_wr;
    assign do_rd    = cfg_en && !cfg_wr;
    assign pend_clr = cfg_en && (idx == REG_PEND);

    // Purpose: software-writable configuration; read-only indices drop writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            cls_q  <= '0;
            tgt0_q <= TGT_INIT;
            tgt1_q <= TGT_INIT;
        end else if (do_wr) begin
            case (idx)
                REG_MASK:  mask_q <= cfg_wdata[NUM_SRC-1:0];
                REG_CLASS: cls_q  <= cfg_wdata[NUM_SRC-1:0];
                REG_TGT0:  tgt0_q <= cfg_wdata;
                REG_TGT1:  tgt1_q <= cfg_wdata;
                default:   ;
            endcase
        end
    end

    // Purpose: sticky rise flags, cleared by any access to the pending index.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_clr ? '0 : pend_q) | rise_i;
    end

    // Purpose: select the register addressed by a read.
    always_comb begin
        case (idx)
            REG_LEVEL: rd_mux = WORD_W'(lvl_i);
            REG_PEND:  rd_mux = WORD_W'(pend_q);
            REG_MASK:  rd_mux = WORD_W'(mask_q);
            REG_CLASS: rd_mux = WORD_W'(cls_q);
            REG_TGT0:  rd_mux = tgt0_q;
            REG_TGT1:  rd_mux = tgt1_q;
            REG_REQ0:  rd_mux = WORD_W'(lvl_i & mask_q & ~cls_q);
            REG_REQ1:  rd_mux = WORD_W'(lvl_i & mask_q & cls_q);
            default:   rd_mux = '0;
        endcase
    end

    // Purpose: register the read data so it is valid one cycle after the access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_rdata  <= '0;
            cfg_rvalid <= 1'b0;
        end else begin
            cfg_rvalid <= do_rd;
            if (do_rd) cfg_rdata <= rd_mux;
        end
    end

    assign mask_o = mask_q;
    assign cls_o  = cls_q;
    assign pend_o = pend_q;
    assign tgt0_o = tgt0_q;
    assign tgt1_o = tgt1_q;

    // R5: after a clear, only edges seen in the clearing cycle may remain.
    a_r5_clear_keeps_only_new: assert property (@(posedge clk) disable iff (!rst_n)
        pend_clr |=> ((pend_q & ~$past(rise_i)) == '0));
endmodule

// File: rtl/irq_msg_queue.sv
// Message queue: one outstanding flag per source plus the class captured at
// the edge. The lowest queued source is loaded into a single output slot,
// which holds until it is acknowledged. The target register is read when a
// message is loaded. A repeat edge on a source already queued merges.
module irq_msg_queue
    import irq_msg_pkg::*;
#(
    parameter int NUM_SRC = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] fire_i,
    input  logic [NUM_SRC-1:0] cls_i,
    input  logic [WORD_W-1:0]  tgt0_i,
    input  logic [WORD_W-1:0]  tgt1_i,
    output logic               msg_req,
    output logic [WORD_W-1:0]  msg_addr,
    output logic [WORD_W-1:0]  msg_data,
    input  logic               msg_ack
);
    logic [NUM_SRC-1:0] mq_q, mcls_q;
    logic [NUM_SRC-1:0] pick, take;
    logic               slot_free, load, pick_cls;
    logic [WORD_W-1:0]  sel_tgt;

    // Purpose: isolate the lowest queued source and choose its target.
    always_comb begin
        pick      = mq_q & (~mq_q + 1'b1);
        slot_free = !msg_req || msg_ack;
        load      = slot_free && (|mq_q);
        take      = load ? pick : '0;
        pick_cls  = |(pick & mcls_q);
        sel_tgt   = pick_cls ? tgt1_i : tgt0_i;
    end

    // Purpose: record new unmasked edges and retire the one being issued.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mq_q   <= '0;
            mcls_q <= '0;
        end else begin
            mq_q   <= (mq_q & ~take) | fire_i;
            mcls_q <= (mcls_q & ~fire_i) | (cls_i & fire_i);
        end
    end

    // Purpose: output slot holding one write request until acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_req  <= 1'b0;
            msg_addr <= '0;
            msg_data <= '0;
        end else if (load) begin
            msg_req  <= 1'b1;
            msg_addr <= {sel_tgt[WORD_W-1:DATA_BITS], {DATA_BITS{1'b0}}};
            msg_data <= WORD_W'(sel_tgt[DATA_BITS-1:0]);
        end else if (msg_ack) begin
            msg_req  <= 1'b0;
        end
    end

    // R8: an unacknowledged request keeps its contents.
    a_r8_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_req && !msg_ack) |=> (msg_req && $stable(msg_addr) && $stable(msg_data)));

    // R9: a new request only starts from a queued source.
    a_r9_issue_from_queue: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_req) |-> $past(|mq_q));

    // R7: a freshly issued message carries one of the two targets, split.
    a_r7_target_split: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_req) |->
            (({msg_addr[WORD_W-1:DATA_BITS], msg_data[DATA_BITS-1:0]} == $past(tgt0_i)) ||
             ({msg_addr[WORD_W-1:DATA_BITS], msg_data[DATA_BITS-1:0]} == $past(tgt1_i))));
endmodule

// File: rtl/irq_msg_ctrl.sv
// Top: interrupt collector that turns unmasked rising source levels into
// 32-bit write messages. Combines the level tracker, the register file and
// the message queue. Assumes synchronous sources and a single master slot.
module irq_msg_ctrl
    import irq_msg_pkg::*;
#(
    parameter int          NUM_SRC  = 11,
    parameter logic [31:0] MSG_BASE = 32'hFFF8_0000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC-1:0]   src_i,
    input  logic                 cfg_en,
    input  logic                 cfg_wr,
    input  logic [REG_IDX_W-1:0] cfg_idx,
    input  logic [WORD_W-1:0]    cfg_wdata,
    output logic [WORD_W-1:0]    cfg_rdata,
    output logic                 cfg_rvalid,
    output logic                 msg_req,
    output logic [WORD_W-1:0]    msg_addr,
    output logic [WORD_W-1:0]    msg_data,
    input  logic                 msg_ack
);
    localparam logic [31:0] TGT_INIT = MSG_BASE + 32'd3;

    logic [NUM_SRC-1:0] lvl, rise, mask, cls, pend, fire;
    logic [WORD_W-1:0]  tgt0, tgt1;

    irq_edge_track #(.NUM_SRC(NUM_SRC)) u_edge (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .lvl_o(lvl), .rise_o(rise)
    );

    irq_regfile #(.NUM_SRC(NUM_SRC), .TGT_INIT(TGT_INIT)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .cfg_en(cfg_en), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .cfg_rvalid(cfg_rvalid),
        .lvl_i(lvl), .rise_i(rise),
        .mask_o(mask), .cls_o(cls), .pend_o(pend), .tgt0_o(tgt0), .tgt1_o(tgt1)
    );

    // Purpose: only unmasked edges become messages.
    always_comb begin
        fire = rise & mask;
    end

    irq_msg_queue #(.NUM_SRC(NUM_SRC)) u_queue (
        .clk(clk), .rst_n(rst_n),
        .fire_i(fire), .cls_i(cls), .tgt0_i(tgt0), .tgt1_i(tgt1),
        .msg_req(msg_req), .msg_addr(msg_addr), .msg_data(msg_data), .msg_ack(msg_ack)
    );

    // R3: a pending bit can only newly appear where the level was low.
    a_r3_pend_needs_low_level: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & ~$past(pend) & $past(lvl)) == '0));
endmodule

// File: tb/irq_msg_ctrl_tb_top.sv
module irq_msg_ctrl_tb_top;
    localparam logic [31:0] RST_TGT = 32'hFFF8_0003;
    localparam logic [31:0] T0 = 32'h1234_5665;
    localparam logic [31:0] T1 = 32'hABCD_EF9E;

    // vector: {src, mask, class, exp_req0, exp_req1}, 11 bits each
    localparam int NV = 5;
    localparam logic [54:0] VEC [NV] = '{
        {11'h001, 11'h001, 11'h000, 11'h001, 11'h000},
        {11'h024, 11'h7FF, 11'h004, 11'h020, 11'h004},
        {11'h0F0, 11'h000, 11'h0F0, 11'h000, 11'h000},
        {11'h7FF, 11'h555, 11'h0F0, 11'h505, 11'h050},
        {11'h400, 11'h400, 11'h400, 11'h000, 11'h400}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] src_i = '0;
    logic        cfg_en = 1'b0, cfg_wr = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        cfg_rvalid;
    logic        msg_req;
    logic [31:0] msg_addr, msg_data;
    logic        msg_ack = 1'b0;

    int checks = 0;
    int failures = 0;
    logic [31:0] rd;

    always #4 clk = ~clk;

    irq_msg_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .src_i(src_i),
        .cfg_en(cfg_en), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .cfg_rvalid(cfg_rvalid),
        .msg_req(msg_req), .msg_addr(msg_addr), .msg_data(msg_data), .msg_ack(msg_ack)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] idx, input logic [31:0] d);
        cfg_en = 1'b1; cfg_wr = 1'b1; cfg_idx = idx; cfg_wdata = d;
        @(negedge clk);
        cfg_en = 1'b0; cfg_wr = 1'b0;
    endtask

    task automatic rdreg(input logic [2:0] idx, output logic [31:0] d);
        cfg_en = 1'b1; cfg_wr = 1'b0; cfg_idx = idx;
        @(negedge clk);
        cfg_en = 1'b0;
        d = cfg_rdata;
        checks++;
        if (!cfg_rvalid) begin
            failures++;
            $display("FAIL R2 rvalid actual=0 expected=1");
        end
    endtask

    // wait for a message, compare it, acknowledge it
    task automatic take_msg(input string req, input logic [31:0] tgt);
        int n = 0;
        while (!msg_req && n < 20) begin @(negedge clk); n++; end
        chk(msg_req, req, {31'd0, msg_req}, 32'd1);
        chk(msg_addr == (tgt & 32'hFFFF_FFE0), req, msg_addr, tgt & 32'hFFFF_FFE0);
        chk(msg_data == (tgt & 32'h1F), req, msg_data, tgt & 32'h1F);
        msg_ack = 1'b1;
        @(negedge clk);
        msg_ack = 1'b0;
    endtask

    task automatic no_msg(input string req);
        bit seen = 0;
        for (int k = 0; k < 4; k++) begin
            if (msg_req) seen = 1;
            @(negedge clk);
        end
        chk(!seen, req, {31'd0, seen}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1 reset state
        chk(msg_req == 1'b0, "R1 msg_req", {31'd0, msg_req}, 32'd0);
        rdreg(3'd0, rd); chk(rd == 0, "R1 level", rd, 0);
        rdreg(3'd1, rd); chk(rd == 0, "R1 pend", rd, 0);
        rdreg(3'd2, rd); chk(rd == 0, "R1 mask", rd, 0);
        rdreg(3'd3, rd); chk(rd == 0, "R1 class", rd, 0);
        rdreg(3'd4, rd); chk(rd == RST_TGT, "R1 tgt0", rd, RST_TGT);
        rdreg(3'd5, rd); chk(rd == RST_TGT, "R1 tgt1", rd, RST_TGT);

        // R10 widths
        wr(3'd4, T0); wr(3'd5, T1);
        rdreg(3'd4, rd); chk(rd == T0, "R10 tgt0 full", rd, T0);
        rdreg(3'd5, rd); chk(rd == T1, "R10 tgt1 full", rd, T1);
        wr(3'd2, 32'hFFFF_FFFF);
        rdreg(3'd2, rd); chk(rd == 32'h7FF, "R10 mask width", rd, 32'h7FF);
        wr(3'd3, 32'hFFFF_FFFF);
        rdreg(3'd3, rd); chk(rd == 32'h7FF, "R10 class width", rd, 32'h7FF);

        // table walk: R2 R4 R7 R9 R5
        for (int v = 0; v < NV; v++) begin
            logic [10:0] s, m, c, e0, e1;
            {s, m, c, e0, e1} = VEC[v];
            src_i = '0; cyc(2);
            wr(3'd1, 32'd0);
            wr(3'd2, {21'd0, m});
            wr(3'd3, {21'd0, c});
            src_i = s; cyc(2);
            rdreg(3'd0, rd); chk(rd == {21'd0, s}, "R2 level", rd, {21'd0, s});
            rdreg(3'd6, rd); chk(rd == {21'd0, e0}, "R4 view0", rd, {21'd0, e0});
            rdreg(3'd7, rd); chk(rd == {21'd0, e1}, "R4 view1", rd, {21'd0, e1});
            for (int b = 0; b < 11; b++)
                if (s[b] && m[b]) take_msg("R7 R9 message", c[b] ? T1 : T0);
            no_msg("R7 no extra message");
            rdreg(3'd1, rd); chk(rd == {21'd0, s}, "R5 pend read", rd, {21'd0, s});
            rdreg(3'd1, rd); chk(rd == 0, "R5 pend cleared by read", rd, 0);
        end

        // R3: held source does not re-pend
        src_i = '0; cyc(2);
        wr(3'd2, 32'h008); wr(3'd3, 32'h0);
        src_i = 11'h008;
        take_msg("R3 first edge message", T0);
        rdreg(3'd1, rd); chk(rd == 32'h8, "R3 pend first", rd, 32'h8);
        no_msg("R3 held no message");
        rdreg(3'd1, rd); chk(rd == 0, "R3 held no pend", rd, 0);
        src_i = '0; cyc(2); src_i = 11'h008;
        take_msg("R3 re-rise message", T0);
        rdreg(3'd1, rd); chk(rd == 32'h8, "R3 re-rise pend", rd, 32'h8);

        // R5: write clears, edge in clearing cycle survives
        src_i = '0; cyc(2);
        wr(3'd2, 32'h0);
        src_i = 11'h010; cyc(2);
        wr(3'd1, 32'h0000_0000);
        rdreg(3'd1, rd); chk(rd == 0, "R5 write clears", rd, 0);
        src_i = '0; cyc(2);
        src_i = 11'h002;
        rdreg(3'd1, rd); chk(rd == 0, "R5 read during edge returns old", rd, 0);
        rdreg(3'd1, rd); chk(rd == 32'h2, "R5 edge kept through clear", rd, 32'h2);

        // R6: read-only registers ignore writes
        src_i = 11'h001; cyc(2);
        wr(3'd2, 32'h0); wr(3'd3, 32'h0);
        wr(3'd0, 32'h7FE);
        rdreg(3'd0, rd); chk(rd == 32'h1, "R6 level ignores write", rd, 32'h1);
        wr(3'd6, 32'h7FF);
        rdreg(3'd6, rd); chk(rd == 0, "R6 view0 ignores write", rd, 0);
        wr(3'd7, 32'h7FF);
        rdreg(3'd7, rd); chk(rd == 0, "R6 view1 ignores write", rd, 0);
        rdreg(3'd2, rd); chk(rd == 0, "R6 mask untouched", rd, 0);

        // R8: hold without ack
        src_i = '0; cyc(2);
        wr(3'd2, 32'h100); wr(3'd3, 32'h100);
        src_i = 11'h100;
        cyc(3);
        for (int k = 0; k < 6; k++) begin
            chk(msg_req && msg_addr == (T1 & 32'hFFFF_FFE0), "R8 hold",
                msg_addr, T1 & 32'hFFFF_FFE0);
            @(negedge clk);
        end
        take_msg("R8 acked message", T1);
        no_msg("R8 released");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule